// File: doc/BRIEF.md
# Flattened Butterfly Route Computation Unit

This block computes the next hop for one router of an n-dimensional flattened butterfly. Routers are numbered so that each base-k digit of the router index is its coordinate in one dimension, and every router serves c terminals. A terminal index therefore identifies a router (index divided by c) and a local slot (index modulo c). For each request the unit returns the output port the flit should leave on and the range of virtual channels it may use there.

Between routers the unit uses minimal dimension-ordered routing in one of two orders: lowest differing dimension first, or highest differing dimension first. A freshly injected packet picks its order by comparing the used-credit counts of the two candidate ports, with ties broken by a pseudo-random bit. A packet already in flight does not carry its order explicitly. The order is recovered from which half of its traffic class VC range it currently occupies, and this keeps the two orders on disjoint channels. Results appear one clock after the request.

Top module: `ffly_route_unit`

## Requirements
- R1: When the request's destination terminal belongs to the current router (terminal index divided by C equals the router ID), the output port is the terminal index modulo C and the VC range is the whole class range.
- R2: Inter-router ports are numbered from C upward. For a dimension d with destination digit a and current digit b, the port is C + (K-1)*d + a - 1 when a > b, and C + (K-1)*d + a when a < b. The router's own coordinate therefore takes no port.
- R3: Router IDs are read as N base-K digits, digit d at bits [d*log2(K) +: log2(K)]. Low-first order routes in the lowest dimension whose digits differ. High-first order routes in the highest such dimension.
- R4: The packet type code selects a class VC range of NUM_VC/4 channels: 1 uses block 0, 2 uses block 1, 3 uses block 2 and 4 uses block 3. Codes 0, 5, 6 and 7 use all NUM_VC channels.
- R5: On an inter-router port, low-first packets receive the lower half of the class range and high-first packets receive the upper half.
- R6: When the input channel index is below C, the order is low-first if the used credits on the low-first candidate port are fewer than on the high-first candidate port, and high-first if they are more. On equal counts the tie bit decides, with 1 meaning low-first.
- R7: When the input channel index is C or more, the order is low-first exactly when the incoming VC is below the class range start plus half the class width.
- R8: The tie bit is bit 0 of a 16-bit shift register that resets to 0xACE1. It shifts left once per valid request and takes in the XOR of bits 15, 13, 12 and 10.
- R9: rsp_valid is req_valid delayed by one clock. The result fields are updated only on the clock edge after a valid request.
- R10: A destination terminal index of K^N*C or more raises rsp_err, with port 0 and the whole class VC range.
- R11: Synchronous reset clears rsp_valid, rsp_err, rsp_port, rsp_vc_lo and rsp_vc_hi to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A routing request is present this cycle |
| req_dest | input | DEST_W | Destination terminal index |
| req_router | input | RID_W | ID of the router doing the computation |
| req_in_chan | input | PORT_W | Input channel the flit arrived on; below C means injected |
| req_vc | input | VC_W | VC the flit currently occupies |
| req_type | input | 3 | Packet type code selecting the class VC range |
| port_credits | input | RADIX*CRED_W | Used-credit count per output port, port p at [p*CRED_W +: CRED_W] |
| rsp_valid | output | 1 | Result registered from the previous cycle's request |
| rsp_port | output | PORT_W | Chosen output port |
| rsp_vc_lo | output | VC_W | First allowed VC |
| rsp_vc_hi | output | VC_W | Last allowed VC |
| rsp_err | output | 1 | Destination outside the network |

## Verification
The properties assume that a flit arriving on an inter-router channel occupies a VC inside its own class range. They also assume the router ID names a real router and that credit counts are stable while a request is presented. The stimulus keeps to these assumptions by drawing the incoming VC only from the class range implied by the type code it also drives. It sets every credit count before raising the request, and it sweeps every real router against every real terminal. Out-of-range terminals are driven on purpose, because the error rule covers them. Credit values are drawn from a narrow range so that equal counts, and with them the tie-break path, occur often.

// File: rtl/ffly_route_pkg.sv
package ffly_route_pkg;

    typedef enum logic [2:0] {
        PK_ANY    = 3'd0,
        PK_RD_REQ = 3'd1,
        PK_WR_REQ = 3'd2,
        PK_RD_RSP = 3'd3,
        PK_WR_RSP = 3'd4
    } pkt_kind_e;

    typedef enum logic [1:0] {
        HOP_EJECT = 2'd0,
        HOP_LOW   = 2'd1,
        HOP_HIGH  = 2'd2,
        HOP_BAD   = 2'd3
    } hop_kind_e;

    localparam logic [15:0] TIE_SEED = 16'hACE1;

    function automatic logic [15:0] tie_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Port index for one dimension; the own coordinate is skipped.
    function automatic int dim_port(input int c, input int k, input int d,
                                    input int dst_dig, input int cur_dig);
        int base;
        base = c + (k - 1) * d;
        return (dst_dig > cur_dig) ? base - 1 + dst_dig : base + dst_dig;
    endfunction

endpackage

// File: rtl/ffly_tie_lfsr.sv
module ffly_tie_lfsr (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic tie_bit
);
    import ffly_route_pkg::*;

    logic [15:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TIE_SEED;
        end else if (step) begin
            state_q <= tie_next(state_q);
        end
    end

    assign tie_bit = state_q[0];

endmodule

// File: rtl/ffly_dim_select.sv
module ffly_dim_select #(
    parameter  int K      = 4,
    parameter  int N      = 2,
    parameter  int C      = 3,
    localparam int LK     = $clog2(K),
    localparam int RID_W  = LK * N,
    localparam int RADIX  = C + (K - 1) * N,
    localparam int PORT_W = $clog2(RADIX)
) (
    input  logic [RID_W-1:0]  cur_rid,
    input  logic [RID_W-1:0]  dst_rid,
    output logic [PORT_W-1:0] low_port,
    output logic [PORT_W-1:0] high_port,
    output logic              any_diff
);
    import ffly_route_pkg::*;

    logic [N-1:0]      diff;
    logic [PORT_W-1:0] dport [N];

    for (genvar d = 0; d < N; d++) begin : g_dim
        logic [LK-1:0] cur_dig;
        logic [LK-1:0] dst_dig;
        assign cur_dig  = cur_rid[d*LK +: LK];
        assign dst_dig  = dst_rid[d*LK +: LK];
        assign diff[d]  = (cur_dig != dst_dig);
        assign dport[d] = PORT_W'(dim_port(C, K, d, int'(dst_dig), int'(cur_dig)));
    end

    // Lowest differing dimension wins for the low-first order.
    always_comb begin
        low_port = '0;
        for (int d = N - 1; d >= 0; d--) begin
            if (diff[d]) low_port = dport[d];
        end
    end

    // Highest differing dimension wins for the high-first order.
    always_comb begin
        high_port = '0;
        for (int d = 0; d < N; d++) begin
            if (diff[d]) high_port = dport[d];
        end
    end

    assign any_diff = |diff;

endmodule

// File: rtl/ffly_vc_plan.sv
module ffly_vc_plan #(
    parameter  int NUM_VC = 8,
    localparam int VC_W   = $clog2(NUM_VC),
    localparam int VPC    = NUM_VC / 4
) (
    input  logic [2:0]                      pkt_type,
    input  logic [VC_W-1:0]                 in_vc,
    input  ffly_route_pkg::hop_kind_e       hop,
    output logic                            in_lower,
    output logic [VC_W-1:0]                 vc_lo,
    output logic [VC_W-1:0]                 vc_hi
);
    import ffly_route_pkg::*;

    logic [VC_W-1:0] cls_lo;
    logic [VC_W-1:0] cls_hi;
    logic [VC_W-1:0] cls_mid;

    always_comb begin
        int lo_i;
        int hi_i;
        case (pkt_type)
            PK_RD_REQ, PK_WR_REQ, PK_RD_RSP, PK_WR_RSP: begin
                lo_i = (int'(pkt_type) - 1) * VPC;
                hi_i = lo_i + VPC - 1;
            end
            default: begin
                lo_i = 0;
                hi_i = NUM_VC - 1;
            end
        endcase
        cls_lo  = VC_W'(lo_i);
        cls_hi  = VC_W'(hi_i);
        cls_mid = VC_W'(lo_i + (hi_i - lo_i + 1) / 2);
    end

    assign in_lower = (in_vc < cls_mid);

    always_comb begin
        case (hop)
            HOP_LOW: begin
                vc_lo = cls_lo;
                vc_hi = cls_mid - VC_W'(1);
            end
            HOP_HIGH: begin
                vc_lo = cls_mid;
                vc_hi = cls_hi;
            end
            default: begin
                vc_lo = cls_lo;
                vc_hi = cls_hi;
            end
        endcase
    end

endmodule

// File: rtl/ffly_route_unit.sv
module ffly_route_unit #(
    parameter  int K      = 4,
    parameter  int N      = 2,
    parameter  int C      = 3,
    parameter  int NUM_VC = 8,
    parameter  int CRED_W = 6,
    localparam int NR     = K ** N,
    localparam int NT     = NR * C,
    localparam int LK     = $clog2(K),
    localparam int RID_W  = LK * N,
    localparam int DEST_W = $clog2(NT),
    localparam int RADIX  = C + (K - 1) * N,
    localparam int PORT_W = $clog2(RADIX),
    localparam int VC_W   = $clog2(NUM_VC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [DEST_W-1:0]       req_dest,
    input  logic [RID_W-1:0]        req_router,
    input  logic [PORT_W-1:0]       req_in_chan,
    input  logic [VC_W-1:0]         req_vc,
    input  logic [2:0]              req_type,
    input  logic [RADIX*CRED_W-1:0] port_credits,
    output logic                    rsp_valid,
    output logic [PORT_W-1:0]       rsp_port,
    output logic [VC_W-1:0]         rsp_vc_lo,
    output logic [VC_W-1:0]         rsp_vc_hi,
    output logic                    rsp_err
);
    import ffly_route_pkg::*;

    logic              out_of_range;
    logic [RID_W-1:0]  dst_rid;
    logic              local_hit;
    logic [PORT_W-1:0] eject_port;
    logic [PORT_W-1:0] low_port;
    logic [PORT_W-1:0] high_port;
    logic              any_diff;
    logic [CRED_W-1:0] cred_low;
    logic [CRED_W-1:0] cred_high;
    logic              injected;
    logic              tie_bit;
    logic              in_lower;
    hop_kind_e         hop;
    logic [PORT_W-1:0] nxt_port;
    logic [VC_W-1:0]   nxt_lo;
    logic [VC_W-1:0]   nxt_hi;

    assign out_of_range = (32'(req_dest) >= NT);
    assign dst_rid      = RID_W'(32'(req_dest) / C);
    assign local_hit    = !out_of_range && (dst_rid == req_router);
    assign eject_port   = PORT_W'(32'(req_dest) % C);
    assign injected     = (32'(req_in_chan) < C);

    ffly_dim_select #(.K(K), .N(N), .C(C)) u_dims (
        .cur_rid   (req_router),
        .dst_rid   (dst_rid),
        .low_port  (low_port),
        .high_port (high_port),
        .any_diff  (any_diff)
    );

    assign cred_low  = port_credits[32'(low_port) * CRED_W +: CRED_W];
    assign cred_high = port_credits[32'(high_port) * CRED_W +: CRED_W];

    ffly_tie_lfsr u_tie (
        .clk     (clk),
        .rst     (rst),
        .step    (req_valid),
        .tie_bit (tie_bit)
    );

    ffly_vc_plan #(.NUM_VC(NUM_VC)) u_vcs (
        .pkt_type (req_type),
        .in_vc    (req_vc),
        .hop      (hop),
        .in_lower (in_lower),
        .vc_lo    (nxt_lo),
        .vc_hi    (nxt_hi)
    );

    always_comb begin
        if (out_of_range || (!local_hit && !any_diff)) begin
            hop = HOP_BAD;
        end else if (local_hit) begin
            hop = HOP_EJECT;
        end else if (injected) begin
            if (cred_low < cred_high)      hop = HOP_LOW;
            else if (cred_low > cred_high) hop = HOP_HIGH;
            else                           hop = tie_bit ? HOP_LOW : HOP_HIGH;
        end else begin
            hop = in_lower ? HOP_LOW : HOP_HIGH;
        end
    end

    always_comb begin
        case (hop)
            HOP_EJECT: nxt_port = eject_port;
            HOP_LOW:   nxt_port = low_port;
            HOP_HIGH:  nxt_port = high_port;
            default:   nxt_port = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_port  <= '0;
            rsp_vc_lo <= '0;
            rsp_vc_hi <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_port  <= nxt_port;
                rsp_vc_lo <= nxt_lo;
                rsp_vc_hi <= nxt_hi;
                rsp_err   <= (hop == HOP_BAD);
            end
        end
    end

endmodule

// File: rtl/ffly_route_sva.sv
module ffly_route_sva #(
    parameter  int K      = 4,
    parameter  int N      = 2,
    parameter  int C      = 3,
    parameter  int NUM_VC = 8,
    localparam int NR     = K ** N,
    localparam int NT     = NR * C,
    localparam int RID_W  = $clog2(K) * N,
    localparam int DEST_W = $clog2(NT),
    localparam int RADIX  = C + (K - 1) * N,
    localparam int PORT_W = $clog2(RADIX),
    localparam int VC_W   = $clog2(NUM_VC),
    localparam int VPC    = NUM_VC / 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [DEST_W-1:0] req_dest,
    input logic [RID_W-1:0]  req_router,
    input logic              rsp_valid,
    input logic [PORT_W-1:0] rsp_port,
    input logic [VC_W-1:0]   rsp_vc_lo,
    input logic [VC_W-1:0]   rsp_vc_hi,
    input logic              rsp_err
);

    p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_vc_order_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_vc_lo <= rsp_vc_hi));

    p_port_range_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (32'(rsp_port) < RADIX));

    p_local_eject_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (32'(req_dest) < NT) && (RID_W'(32'(req_dest) / C) == req_router))
        |=> ((32'(rsp_port) < C) && !rsp_err));

    p_bad_dest_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (32'(req_dest) >= NT)) |=> (rsp_err && (rsp_port == '0)));

    p_half_width_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err && (32'(rsp_port) >= C))
        |-> (((32'(rsp_vc_hi) - 32'(rsp_vc_lo) + 1) == VPC / 2) ||
             ((32'(rsp_vc_hi) - 32'(rsp_vc_lo) + 1) == NUM_VC / 2)));

endmodule

bind ffly_route_unit ffly_route_sva #(.K(K), .N(N), .C(C), .NUM_VC(NUM_VC)) u_route_sva (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_dest   (req_dest),
    .req_router (req_router),
    .rsp_valid  (rsp_valid),
    .rsp_port   (rsp_port),
    .rsp_vc_lo  (rsp_vc_lo),
    .rsp_vc_hi  (rsp_vc_hi),
    .rsp_err    (rsp_err)
);

// File: tb/ffly_route_unit_tb_top.sv
`timescale 1ns/1ps
module ffly_route_unit_tb_top;

    localparam int K      = 4;
    localparam int N      = 2;
    localparam int C      = 3;
    localparam int NUM_VC = 8;
    localparam int CRED_W = 6;
    localparam int NR     = K ** N;
    localparam int NT     = NR * C;
    localparam int LK     = $clog2(K);
    localparam int RID_W  = LK * N;
    localparam int DEST_W = $clog2(NT);
    localparam int RADIX  = C + (K - 1) * N;
    localparam int PORT_W = $clog2(RADIX);
    localparam int VC_W   = $clog2(NUM_VC);
    localparam int VPC    = NUM_VC / 4;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    req_valid = 1'b0;
    logic [DEST_W-1:0]       req_dest = '0;
    logic [RID_W-1:0]        req_router = '0;
    logic [PORT_W-1:0]       req_in_chan = '0;
    logic [VC_W-1:0]         req_vc = '0;
    logic [2:0]              req_type = '0;
    logic [RADIX*CRED_W-1:0] port_credits = '0;
    logic                    rsp_valid;
    logic [PORT_W-1:0]       rsp_port;
    logic [VC_W-1:0]         rsp_vc_lo;
    logic [VC_W-1:0]         rsp_vc_hi;
    logic                    rsp_err;

    always #2.5 clk = ~clk;

    ffly_route_unit #(.K(K), .N(N), .C(C), .NUM_VC(NUM_VC), .CRED_W(CRED_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_dest(req_dest),
        .req_router(req_router), .req_in_chan(req_in_chan), .req_vc(req_vc),
        .req_type(req_type), .port_credits(port_credits), .rsp_valid(rsp_valid),
        .rsp_port(rsp_port), .rsp_vc_lo(rsp_vc_lo), .rsp_vc_hi(rsp_vc_hi), .rsp_err(rsp_err)
    );

    typedef struct {
        bit    valid;
        int    port;
        int    lo;
        int    hi;
        bit    err;
        string tag;
        int    rt;
        int    dst;
    } exp_t;

    exp_t        sbq[$];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [15:0] tie_model = 16'hACE1;
    int          cr[RADIX];

    function automatic int digit(input int id, input int d);
        return (id >> (d * LK)) & (K - 1);
    endfunction

    function automatic int hop_port(input int d, input int a, input int b);
        return (a > b) ? C + (K - 1) * d + a - 1 : C + (K - 1) * d + a;
    endfunction

    task automatic check(input string tag, input int act, input int exp_v, input string what);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp_v);
        end
    endtask

    task automatic idle_cycle();
        exp_t e;
        @(negedge clk);
        req_valid = 1'b0;
        e.valid = 1'b0; e.port = 0; e.lo = 0; e.hi = 0; e.err = 1'b0;
        e.tag = "R9"; e.rt = 0; e.dst = 0;
        sbq.push_back(e);
    endtask

    task automatic drive(input int rt, input int dst, input int ty, input int ch, input int vc);
        exp_t e;
        int   clo, chi, half, pl, ph, tie;
        bit   low_first;
        @(negedge clk);
        if (ty >= 1 && ty <= 4) begin
            clo = (ty - 1) * VPC; chi = clo + VPC - 1;
        end else begin
            clo = 0; chi = NUM_VC - 1;
        end
        half = (chi - clo + 1) / 2;
        tie  = int'(tie_model[0]);
        tie_model = {tie_model[14:0], tie_model[15] ^ tie_model[13] ^ tie_model[12] ^ tie_model[10]};
        for (int p = 0; p < RADIX; p++) port_credits[p*CRED_W +: CRED_W] = CRED_W'(cr[p]);
        req_valid   = 1'b1;
        req_dest    = DEST_W'(dst);
        req_router  = RID_W'(rt);
        req_in_chan = PORT_W'(ch);
        req_vc      = VC_W'(vc);
        req_type    = 3'(ty);
        e.valid = 1'b1; e.rt = rt; e.dst = dst; e.err = 1'b0;
        if (dst >= NT) begin
            e.err = 1'b1; e.port = 0; e.lo = clo; e.hi = chi; e.tag = "R10 R4";
        end else if (dst / C == rt) begin
            e.port = dst % C; e.lo = clo; e.hi = chi; e.tag = "R1 R4";
        end else begin
            pl = -1; ph = -1;
            for (int d = 0; d < N; d++)
                if (pl < 0 && digit(dst / C, d) != digit(rt, d))
                    pl = hop_port(d, digit(dst / C, d), digit(rt, d));
            for (int d = N - 1; d >= 0; d--)
                if (ph < 0 && digit(dst / C, d) != digit(rt, d))
                    ph = hop_port(d, digit(dst / C, d), digit(rt, d));
            if (ch < C) begin
                if (cr[pl] < cr[ph])      low_first = 1'b1;
                else if (cr[pl] > cr[ph]) low_first = 1'b0;
                else                      low_first = (tie == 1);
                e.tag = "R2 R3 R5 R6 R8";
            end else begin
                low_first = (vc < clo + half);
                e.tag = "R2 R3 R5 R7";
            end
            if (low_first) begin
                e.port = pl; e.lo = clo; e.hi = clo + half - 1;
            end else begin
                e.port = ph; e.lo = clo + half; e.hi = chi;
            end
        end
        sbq.push_back(e);
    endtask

    task automatic random_request(input int rt, input int dst);
        int ty, ch, vc, clo, chi;
        ty = int'($urandom_range(7));
        ch = int'($urandom_range(RADIX - 1));
        if (ty >= 1 && ty <= 4) begin
            clo = (ty - 1) * VPC; chi = clo + VPC - 1;
        end else begin
            clo = 0; chi = NUM_VC - 1;
        end
        vc = clo + int'($urandom_range(chi - clo));
        for (int p = 0; p < RADIX; p++) cr[p] = int'($urandom_range(3));
        drive(rt, dst, ty, ch, vc);
    endtask

    // Monitor: one expected item per cycle once the driver has started.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check("R9", int'(rsp_valid), int'(e.valid), "rsp_valid");
                if (e.valid) begin
                    n_checks++;
                    if (int'(rsp_port) != e.port || int'(rsp_vc_lo) != e.lo ||
                        int'(rsp_vc_hi) != e.hi || rsp_err != e.err) begin
                        n_fail++;
                        $display("FAIL %s router %0d dest %0d: actual port %0d vc %0d..%0d err %0d expected port %0d vc %0d..%0d err %0d",
                                 e.tag, e.rt, e.dst, rsp_port, rsp_vc_lo, rsp_vc_hi, rsp_err,
                                 e.port, e.lo, e.hi, e.err);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < RADIX; p++) cr[p] = 0;
        repeat (4) @(negedge clk);
        // R11: reset state
        check("R11", int'(rsp_valid), 0, "rsp_valid in reset");
        check("R11", int'(rsp_port), 0, "rsp_port in reset");
        check("R11", int'(rsp_vc_lo), 0, "rsp_vc_lo in reset");
        check("R11", int'(rsp_vc_hi), 0, "rsp_vc_hi in reset");
        check("R11", int'(rsp_err), 0, "rsp_err in reset");
        rst = 1'b0;

        // Directed R6: low-first port cheaper, then dearer (router 0 to router 5).
        for (int p = 0; p < RADIX; p++) cr[p] = 2;
        cr[hop_port(0, 1, 0)] = 0;
        drive(0, 5 * C, 1, 0, 0);
        cr[hop_port(0, 1, 0)] = 3;
        drive(0, 5 * C, 1, 0, 0);
        // Directed R8: equal credits, tie bit decides over several requests.
        for (int p = 0; p < RADIX; p++) cr[p] = 1;
        for (int i = 0; i < 6; i++) drive(0, 5 * C, 0, 1, 0);
        // Directed R7: in-flight packet in each half of the read-reply class.
        drive(6, 9 * C + 1, 3, C, 2 * VPC);
        drive(6, 9 * C + 1, 3, C, 3 * VPC - 1);
        idle_cycle();

        // Full sweep of routers against terminals, with idle gaps.
        for (int rt = 0; rt < NR; rt++) begin
            for (int dst = 0; dst < NT; dst++) begin
                random_request(rt, dst);
                if ((dst % 17) == 5) idle_cycle();
            end
        end
        // R10: terminals past the network.
        for (int dst = NT; dst < (1 << DEST_W); dst++) random_request(dst % NR, dst);
        idle_cycle();
        idle_cycle();
        while (sbq.size() > 0) @(posedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule